// File: doc/BRIEF.md
# Two-Level Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds several banks of 2-bit saturating counters. A short global shift register stores the outcomes of the most recent resolved branches, and its value chooses the bank. A slice of the branch address chooses the entry within that bank. A lookup is purely combinational: the fetch or decode logic presents a PC and receives a taken / not-taken answer in the same cycle. It also receives the history value that was used for that answer, and it carries that value down the pipeline with the branch.

When a conditional branch resolves, the pipeline sends one training message. This happens for every branch, whether it was predicted correctly or not. The message carries the branch PC, the real outcome, and the history value captured at prediction time. Training moves the addressed counter one step toward the outcome and shifts the outcome into the global history.

Each counter is a four-state machine with these states:
- `CTR_SNT` (strong not-taken, code 00)
- `CTR_WNT` (weak not-taken, code 01)
- `CTR_WT` (weak taken, code 10)
- `CTR_ST` (strong taken, code 11)

A taken outcome steps the counter up: SNT→WNT, WNT→WT, WT→ST, and ST stays at ST. A not-taken outcome steps it down: ST→WT, WT→WNT, WNT→SNT, and SNT stays at SNT. A training message is the only event that moves a counter.

Top module: `dir_pred_2lvl`

## Requirements
- R1: After reset every counter holds code 01 (weak not-taken) and the history register holds all zeros, so every lookup answers not-taken with `lkp_hist` = 0.
- R2: A taken training message raises the addressed counter by one, saturating at 11. A not-taken message lowers it by one, saturating at 00.
- R3: `lkp_taken` equals bit 1 of the selected counter: 1 (taken) for codes 10 and 11, 0 for codes 00 and 01.
- R4: On each cycle with `upd_valid` high, the history shifts left by one and `upd_taken` enters bit 0, so bit 0 is the newest outcome. Without `upd_valid` the history holds its value. `lkp_hist` shows the current history.
- R5: A lookup reads the bank numbered by the current history, at entry `lkp_pc[IDX_W+1:2]`. PC bits 1:0 and all bits above `IDX_W+1` have no effect on the answer.
- R6: Training writes the bank numbered by `upd_hist`, not the bank numbered by the current history, at entry `upd_pc[IDX_W+1:2]`.
- R7: Because every resolved branch trains, a strongly-taken entry keeps answering taken after a single not-taken outcome. The answer flips only after two wrong outcomes in a row.
- R8: When a lookup and a training message address the same entry in the same cycle, the lookup returns the value from before the update.
- R9: Training changes only the addressed entry. Entries with a different index, or in a different bank, keep their values.
- R10: For a pair of branches where the second always repeats the outcome of the first, the second branch is predicted correctly every time after a warm-up period. For a loop branch taken seven times then not taken once, the steady state has exactly one miss per loop, at the exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_pc | input | PC_W | PC of the branch being predicted |
| lkp_taken | output | 1 | Predicted direction, 1 = taken |
| lkp_hist | output | HIST_W | History value used for this prediction |
| upd_valid | input | 1 | A resolved branch is being reported |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_W | History captured when the branch was predicted |

## Verification
A corrupted counter shows up at `lkp_taken` on the first lookup that uses the same history and index after the faulty write. Because the lookup is combinational, this can happen one cycle later. A wrong history shift shows up directly on `lkp_hist` in the next cycle. It also makes later lookups read the wrong bank, which the bench detects by comparing against its own model. A wrong bank choice during training stays hidden until the history returns to the bank that should have changed. For that reason the directed tests steer the history explicitly before every read-back.

// File: rtl/bp_pkg.sv
package bp_pkg;

    // Per-entry 2-bit saturating counter state
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_e;

    localparam ctr_state_e CTR_RESET = CTR_WNT;

    // One training step toward the resolved outcome
    function automatic ctr_state_e ctr_next(ctr_state_e cur, logic taken);
        ctr_state_e nxt;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = CTR_RESET;
        endcase
        return nxt;
    endfunction

    // Predicted direction is the counter's upper bit
    function automatic logic ctr_dir(ctr_state_e cur);
        logic [1:0] raw;
        raw = cur;
        return raw[1];
    endfunction

endpackage

// File: rtl/bp_hist_reg.sv
module bp_hist_reg #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    // Next-value process: newest outcome enters at bit 0
    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;

endmodule

// File: rtl/bp_pc_index.sv
module bp_pc_index #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 8
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);

    localparam int LSB = 2;
    localparam int MSB = IDX_W + LSB - 1;

    // Byte-offset bits and upper bits take no part in indexing
    logic unused_pc_bits;
    assign unused_pc_bits = ^{pc[PC_W-1:MSB+1], pc[LSB-1:0]};

    assign idx = pc[MSB:LSB];

endmodule

// File: rtl/bp_ctr_bank.sv
module bp_ctr_bank
    import bp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_state_e       rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_state_e ctr_q [DEPTH];
    ctr_state_e wr_next;

    // Transition for the entry under training
    always_comb begin
        wr_next = ctr_next(ctr_q[wr_idx], wr_taken);
    end

    // State registers of all counters in the bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ctr_q[i] <= CTR_RESET;
            end
        end else if (wr_en) begin
            ctr_q[wr_idx] <= wr_next;
        end
    end

    // Read sees the registered value: old data on same-cycle write
    assign rd_state = ctr_q[rd_idx];

endmodule

// File: rtl/dir_pred_2lvl.sv
module dir_pred_2lvl
    import bp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PC_W-1:0]   lkp_pc,
    output logic              lkp_taken,
    output logic [HIST_W-1:0] lkp_hist,
    input  logic              upd_valid,
    input  logic [PC_W-1:0]   upd_pc,
    input  logic              upd_taken,
    input  logic [HIST_W-1:0] upd_hist
);

    localparam int NUM_BANKS = 1 << HIST_W;

    logic [IDX_W-1:0]  rd_idx;
    logic [IDX_W-1:0]  wr_idx;
    logic [HIST_W-1:0] hist;
    ctr_state_e        bank_rd [NUM_BANKS];
    ctr_state_e        sel_state;

    bp_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_rd_index (
        .pc  (lkp_pc),
        .idx (rd_idx)
    );

    bp_pc_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_wr_index (
        .pc  (upd_pc),
        .idx (wr_idx)
    );

    bp_hist_reg #(.HIST_W(HIST_W)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .hist      (hist)
    );

    // One counter bank per history value; the carried history picks the trained bank
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bp_ctr_bank #(.IDX_W(IDX_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (rd_idx),
            .rd_state (bank_rd[b]),
            .wr_en    (upd_valid && (upd_hist == HIST_W'(b))),
            .wr_idx   (wr_idx),
            .wr_taken (upd_taken)
        );
    end

    // Output process: current history picks the bank that answers
    always_comb begin
        sel_state = bank_rd[hist];
        lkp_taken = ctr_dir(sel_state);
        lkp_hist  = hist;
    end

endmodule

// File: rtl/dir_pred_2lvl_chk.sv
module dir_pred_2lvl_chk #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   lkp_pc,
    input logic              lkp_taken,
    input logic [HIST_W-1:0] lkp_hist,
    input logic              upd_valid,
    input logic [PC_W-1:0]   upd_pc,
    input logic              upd_taken,
    input logic [HIST_W-1:0] upd_hist
);

    logic [IDX_W-1:0] li;
    logic [IDX_W-1:0] ui;
    assign li = lkp_pc[IDX_W+1:2];
    assign ui = upd_pc[IDX_W+1:2];

    logic unused_chk;
    assign unused_chk = ^{lkp_pc[PC_W-1:IDX_W+2], lkp_pc[1:0], upd_pc[PC_W-1:IDX_W+2], upd_pc[1:0]};

    AST_RESET_HIST: assert property (@(posedge clk) $rose(rst_n) |-> (lkp_hist == '0)); // R1

    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |=> (lkp_hist == {$past(lkp_hist[HIST_W-2:0]), $past(upd_taken)})); // R4

    AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid |=> $stable(lkp_hist)); // R4

    AST_STAY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_valid) && $past(upd_taken) && $past(lkp_taken) &&
         ($past(li) == $past(ui)) && ($past(lkp_hist) == $past(upd_hist)) &&
         (li == $past(ui)) && (lkp_hist == $past(upd_hist))) |-> lkp_taken); // R2

    AST_STAY_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(upd_valid) && !$past(upd_taken) && !$past(lkp_taken) &&
         ($past(li) == $past(ui)) && ($past(lkp_hist) == $past(upd_hist)) &&
         (li == $past(ui)) && (lkp_hist == $past(upd_hist))) |-> !lkp_taken); // R2

endmodule

bind dir_pred_2lvl dir_pred_2lvl_chk #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_pc    (lkp_pc),
    .lkp_taken (lkp_taken),
    .lkp_hist  (lkp_hist),
    .upd_valid (upd_valid),
    .upd_pc    (upd_pc),
    .upd_taken (upd_taken),
    .upd_hist  (upd_hist)
);

// File: tb/dir_pred_2lvl_bench.sv
module dir_pred_2lvl_bench;

    localparam int PC_W   = 32;
    localparam int IDX_W  = 8;
    localparam int HIST_W = 2;
    localparam int NB     = 1 << HIST_W;
    localparam int DEP    = 1 << IDX_W;
    localparam logic [31:0] DUMMY = 32'h0000_03FC;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PC_W-1:0]   lkp_pc = '0;
    logic              lkp_taken;
    logic [HIST_W-1:0] lkp_hist;
    logic              upd_valid = 1'b0;
    logic [PC_W-1:0]   upd_pc = '0;
    logic              upd_taken = 1'b0;
    logic [HIST_W-1:0] upd_hist = '0;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int mctr [NB][DEP];
    int mhist;

    always #4 clk = ~clk;

    dir_pred_2lvl #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_dir_pred_2lvl (
        .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp_taken),
        .lkp_hist(lkp_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_hist(upd_hist)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int idx_of(logic [31:0] pc);
        return int'(pc[IDX_W+1:2]);
    endfunction

    task automatic model_train(logic [31:0] pc, bit t, int h);
        int i = idx_of(pc);
        if (t && mctr[h][i] < 3) mctr[h][i]++;
        if (!t && mctr[h][i] > 0) mctr[h][i]--;
        mhist = ((mhist << 1) | int'(t)) & (NB - 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        upd_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int b = 0; b < NB; b++)
            for (int i = 0; i < DEP; i++) mctr[b][i] = 1;
        mhist = 0;
    endtask

    task automatic train(logic [31:0] pc, bit t, int h);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc = pc;
        upd_taken = t;
        upd_hist = HIST_W'(h);
        @(posedge clk);
        #1 upd_valid = 1'b0;
        model_train(pc, t, h);
    endtask

    task automatic look(logic [31:0] pc, output bit p, output int h);
        @(negedge clk);
        lkp_pc = pc;
        #1;
        p = lkp_taken;
        h = int'(lkp_hist);
    endtask

    task automatic set_hist(int v);
        train(DUMMY, v[1], mhist);
        train(DUMMY, v[0], mhist);
    endtask

    // One branch: predict and train with the captured history in one cycle
    task automatic branch(logic [31:0] pc, bit t, output bit p);
        int h;
        @(negedge clk);
        lkp_pc = pc;
        #1;
        p = lkp_taken;
        h = int'(lkp_hist);
        check("R10 model", int'(p), mctr[mhist][idx_of(pc)] >> 1);
        upd_valid = 1'b1;
        upd_pc = pc;
        upd_taken = t;
        upd_hist = HIST_W'(h);
        @(posedge clk);
        #1 upd_valid = 1'b0;
        model_train(pc, t, h);
    endtask

    task automatic t_reset_state();
        bit p; int h;
        do_reset();
        look(32'h0000_0100, p, h);
        check("R1 pred", int'(p), 0);
        check("R1 hist", h, 0);
        look(32'hFFFF_FFFC, p, h);
        check("R1 pred high pc", int'(p), 0);
    endtask

    task automatic t_history();
        bit p; int h;
        do_reset();
        train(DUMMY, 1'b1, 0);
        look(DUMMY, p, h); check("R4 after T", h, 1);
        train(DUMMY, 1'b0, 1);
        look(DUMMY, p, h); check("R4 after TN", h, 2);
        train(DUMMY, 1'b1, 2);
        repeat (3) @(posedge clk);
        look(DUMMY, p, h); check("R4 hold", h, 1);
    endtask

    task automatic t_counter();
        bit p; int h;
        logic [31:0] a = 32'h0000_0100;
        bit seq_t   [13] = '{1,1,0,0,0,0,1,1,1,1,1,0,0};
        int seq_exp [13] = '{1,1,1,0,0,0,0,1,1,1,1,1,0};
        do_reset();
        for (int s = 0; s < 13; s++) begin
            train(a, seq_t[s], 0);
            set_hist(0);
            look(a, p, h);
            if (s == 2 || s == 11) check("R7 hysteresis", int'(p), seq_exp[s]);
            else if (s == 5 || s == 6 || s == 10) check("R2 saturate", int'(p), seq_exp[s]);
            else check("R3 upper bit", int'(p), seq_exp[s]);
        end
    endtask

    task automatic t_index();
        bit p; int h;
        do_reset();
        train(32'h0000_0100, 1'b1, 0);
        set_hist(0);
        look(32'h0000_0101, p, h); check("R5 byte offset", int'(p), 1);
        look(32'h0000_0103, p, h); check("R5 byte offset 3", int'(p), 1);
        look(32'h0000_0500, p, h); check("R5 upper alias", int'(p), 1);
        look(32'h0000_0104, p, h); check("R9 neighbour", int'(p), 0);
    endtask

    task automatic t_bank_select();
        bit p; int h;
        logic [31:0] b = 32'h0000_0200;
        do_reset();
        set_hist(1);
        train(b, 1'b1, 2);
        train(b, 1'b1, 2);
        set_hist(1);
        look(b, p, h); check("R6 current bank untouched", int'(p), 0);
        set_hist(2);
        look(b, p, h); check("R6 carried bank trained", int'(p), 1);
        set_hist(0);
        look(b, p, h); check("R9 other bank", int'(p), 0);
    endtask

    task automatic t_same_cycle();
        bit p; int h;
        logic [31:0] c = 32'h0000_0300;
        do_reset();
        @(negedge clk);
        lkp_pc = c;
        upd_valid = 1'b1; upd_pc = c; upd_taken = 1'b1; upd_hist = '0;
        #1 check("R8 old value", int'(lkp_taken), 0);
        @(posedge clk);
        #1 upd_valid = 1'b0;
        model_train(c, 1'b1, 0);
        set_hist(0);
        look(c, p, h); check("R8 write landed", int'(p), 1);
    endtask

    task automatic t_correlated();
        bit p;
        int miss = 0;
        logic [7:0] lfsr = 8'hA5;
        do_reset();
        for (int it = 0; it < 200; it++) begin
            bit x;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            x = lfsr[0];
            branch(32'h0000_1000, x, p);
            branch(32'h0000_1004, x, p);
            if (it >= 40 && p != x) miss++;
        end
        check("R10 correlated misses", miss, 0);
    endtask

    task automatic t_loop();
        bit p;
        int miss = 0;
        int exit_miss = 0;
        do_reset();
        for (int it = 0; it < 30; it++) begin
            for (int k = 0; k < 8; k++) begin
                bit t = (k != 7);
                branch(32'h0000_2000, t, p);
                if (it >= 20 && p != t) begin
                    miss++;
                    if (k == 7) exit_miss++;
                end
            end
        end
        check("R10 loop misses", miss, 10);
        check("R10 loop exit misses", exit_miss, 10);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_history();
        t_counter();
        t_index();
        t_bank_select();
        t_same_cycle();
        t_correlated();
        t_loop();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule